// File: doc/BRIEF.md
# Two-Level Cascaded Interrupt Controller with Acknowledge Vectoring

This block joins two eight-line priority controllers into one sixteen-source interrupt system. Sources 0 to 7 feed the first (primary) controller and sources 8 to 15 feed the second (secondary) controller. Whenever the secondary controller has a request it would serve, it raises a request on line 2 of the primary controller. The primary controller then drives a single interrupt line to the processor.

When the processor answers with a one-cycle acknowledge strobe, the block works out the 8-bit vector. It marks the primary winner in service. If that winner is the cascade line, it also marks the secondary winner in service and returns the secondary vector. If a controller has nothing to offer at acknowledge time, the block returns that controller's line-7 vector as a spurious reply.

Each controller holds a trigger-select register that picks edge or level detection per line. Only a fixed set of bits in each register can be written. The per-line masks, the vector bases and the end-of-service strobes come from the programming logic that sits beside this block.

Top module: `pic_cascade`

## Requirements
- R1: Source n goes to controller n>>3 (0 = primary, 1 = secondary) at line n&7. A serviced secondary line k returns vector {sec_base_i, k}.
- R2: A line in edge mode (trigger-select bit 0) latches a request on a rising input. The request stays pending after the input falls, until it is acknowledged.
- R3: A line in level mode (trigger-select bit 1) is pending only while its input is high. Acknowledge does not clear it, so it is requested again after end of service while the input stays high.
- R4: Among unmasked pending lines, the lowest index wins. A line is offered only if its index is below that of every in-service line of the same controller.
- R5: A pending secondary request sets a request on primary line 2. cpu_irq_o rises two clock edges after a secondary source rises, and one edge after a primary source rises.
- R6: An acknowledge while a primary line k other than 2 wins returns vec_o = {pri_base_i, k}, with vec_valid_o high for exactly the one cycle after ack_i. That line then enters service, and its edge request is cleared.
- R7: An acknowledge while primary line 2 wins puts both the primary line 2 and the secondary winner in service.
- R8: A cascaded acknowledge that finds no secondary winner returns {sec_base_i, 3'd7}.
- R9: An acknowledge while the primary controller has no winner returns {pri_base_i, 3'd7} and changes no state.
- R10: A write to a trigger-select register stores the data ANDed with 0xF8 (primary) or 0xDE (secondary). The register holds its value otherwise and resets to 0, and sel_o reads it back with the primary in the low byte.
- R11: eoi_i[c] removes the lowest-index in-service line of controller c.
- R12: cpu_irq_o is high exactly when the primary controller has a winner, and it is re-evaluated after every acknowledge, end of service, mask or input change.
- R13: A line with mask_i set is never offered. An edge it latched while masked is offered once the mask is cleared.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| irq_i | input | 16 | Interrupt sources; bits 7:0 primary, 15:8 secondary |
| mask_i | input | 16 | Per-source mask, 1 blocks the line |
| pri_base_i | input | 5 | Upper vector bits for the primary controller |
| sec_base_i | input | 5 | Upper vector bits for the secondary controller |
| eoi_i | input | 2 | End-of-service strobe per controller (bit 0 primary) |
| sel_we_i | input | 2 | Trigger-select write enable per controller |
| sel_wdata_i | input | 8 | Trigger-select write data |
| sel_o | output | 16 | Trigger-select readback; 7:0 primary, 15:8 secondary |
| ack_i | input | 1 | One-cycle processor acknowledge |
| cpu_irq_o | output | 1 | Interrupt request to the processor |
| vec_valid_o | output | 1 | Vector valid, one cycle after ack_i |
| vec_o | output | 8 | Acknowledge vector |

## Verification
The acknowledge path is tried with a single primary edge source, two simultaneous primary sources, a higher source arriving while a lower one is in service, and a secondary source through the cascade. Together these separate index-order priority from the nesting block and show whether the cascade line selects the secondary base. Level sources that drop before acknowledge, and a secondary level source that disappears after the cascade request has latched, separate edge latching from level following and produce the secondary spurious vector. An acknowledge with nothing pending checks the primary spurious reply. Two lines in service with a third pending in between them show whether end of service removes the right one.

// File: rtl/pic_cascade_pkg.sv
package pic_cascade_pkg;
  localparam int unsigned LINES   = 8;
  localparam int unsigned IDX_W   = $clog2(LINES);
  localparam int unsigned VEC_W   = 8;
  localparam int unsigned BASE_W  = VEC_W - IDX_W;
  localparam int unsigned N_CTRL  = 2;
  localparam int unsigned CASCADE = 2;

  typedef logic [LINES-1:0]  line_vec_t;
  typedef logic [IDX_W-1:0]  line_idx_t;
  typedef logic [BASE_W-1:0] base_t;
endpackage

// File: rtl/pic_prio_enc.sv
module pic_prio_enc #(
  parameter int unsigned N = 8,
  parameter int unsigned W = 3
) (
  input  logic [N-1:0] req_i,
  output logic         any_o,
  output logic [W-1:0] idx_o
);
  always_comb begin
    any_o = 1'b0;
    idx_o = '0;
    for (int i = N - 1; i >= 0; i--) begin
      if (req_i[i]) begin
        any_o = 1'b1;
        idx_o = W'(i);
      end
    end
  end
endmodule

// File: rtl/pic_sel_reg.sv
module pic_sel_reg #(
  parameter int unsigned         W     = 8,
  parameter logic        [W-1:0] WMASK = '1
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic         we_i,
  input  logic [W-1:0] wdata_i,
  output logic [W-1:0] q_o
);
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)   q_o <= '0;
    else if (we_i) q_o <= wdata_i & WMASK;
  end
endmodule

// File: rtl/pic_core.sv
module pic_core
  import pic_cascade_pkg::*;
(
  input  logic      clk_i,
  input  logic      rst_ni,
  input  line_vec_t line_i,
  input  line_vec_t force_i,   // unconditional request set (cascade)
  input  line_vec_t level_i,   // 1 = level mode
  input  line_vec_t mask_i,
  input  logic      ack_i,
  input  logic      eoi_i,
  output logic      win_valid_o,
  output line_idx_t win_idx_o
);
  line_vec_t irr_q, isr_q, last_q;
  line_vec_t req, set_v, drop_v, ack_clr, ack_set, eoi_clr;
  logic      req_any, isr_any;
  line_idx_t req_idx, isr_idx;

  assign req = irr_q & ~mask_i;

  pic_prio_enc #(.N(LINES), .W(IDX_W)) i_req_enc (
    .req_i(req), .any_o(req_any), .idx_o(req_idx)
  );
  pic_prio_enc #(.N(LINES), .W(IDX_W)) i_isr_enc (
    .req_i(isr_q), .any_o(isr_any), .idx_o(isr_idx)
  );

  assign win_valid_o = req_any && (!isr_any || (req_idx < isr_idx));
  assign win_idx_o   = req_idx;

  always_comb begin
    set_v   = (~level_i & line_i & ~last_q) | (level_i & line_i) | force_i;
    drop_v  = level_i & ~line_i;
    ack_set = '0;
    eoi_clr = '0;
    if (ack_i && win_valid_o) ack_set[win_idx_o] = 1'b1;
    if (eoi_i && isr_any)     eoi_clr[isr_idx]   = 1'b1;
    ack_clr = ack_set & ~level_i;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      irr_q  <= '0;
      isr_q  <= '0;
      last_q <= '0;
    end else begin
      last_q <= line_i;
      irr_q  <= (irr_q | set_v) & ~(ack_clr | drop_v);
      isr_q  <= (isr_q & ~eoi_clr) | ack_set;
    end
  end
endmodule

// File: rtl/pic_cascade.sv
module pic_cascade
  import pic_cascade_pkg::*;
#(
  parameter logic [LINES-1:0] MASTER_SEL_MASK = 8'hF8,
  parameter logic [LINES-1:0] SLAVE_SEL_MASK  = 8'hDE
) (
  input  logic                      clk_i,
  input  logic                      rst_ni,
  input  logic [N_CTRL*LINES-1:0]   irq_i,
  input  logic [N_CTRL*LINES-1:0]   mask_i,
  input  logic [BASE_W-1:0]         pri_base_i,
  input  logic [BASE_W-1:0]         sec_base_i,
  input  logic [N_CTRL-1:0]         eoi_i,
  input  logic [N_CTRL-1:0]         sel_we_i,
  input  logic [LINES-1:0]          sel_wdata_i,
  output logic [N_CTRL*LINES-1:0]   sel_o,
  input  logic                      ack_i,
  output logic                      cpu_irq_o,
  output logic                      vec_valid_o,
  output logic [VEC_W-1:0]          vec_o
);
  logic      [N_CTRL-1:0] win_valid, core_ack;
  line_idx_t              win_idx [N_CTRL];
  line_vec_t              force_v [N_CTRL];
  logic                   casc_hit;

  assign casc_hit = win_valid[0] && (win_idx[0] == line_idx_t'(CASCADE));

  always_comb begin
    force_v[0]          = '0;
    force_v[0][CASCADE] = win_valid[1];
    force_v[1]          = '0;
    core_ack[0]         = ack_i;
    core_ack[1]         = ack_i && casc_hit;
  end

  for (genvar c = 0; c < N_CTRL; c++) begin : g_ctrl
    localparam logic [LINES-1:0] WMASK = (c == 0) ? MASTER_SEL_MASK : SLAVE_SEL_MASK;
    line_vec_t sel_q;

    pic_sel_reg #(.W(LINES), .WMASK(WMASK)) i_sel (
      .clk_i   (clk_i),
      .rst_ni  (rst_ni),
      .we_i    (sel_we_i[c]),
      .wdata_i (sel_wdata_i),
      .q_o     (sel_q)
    );
    assign sel_o[c*LINES +: LINES] = sel_q;

    pic_core i_core (
      .clk_i       (clk_i),
      .rst_ni      (rst_ni),
      .line_i      (irq_i[c*LINES +: LINES]),
      .force_i     (force_v[c]),
      .level_i     (sel_q),
      .mask_i      (mask_i[c*LINES +: LINES]),
      .ack_i       (core_ack[c]),
      .eoi_i       (eoi_i[c]),
      .win_valid_o (win_valid[c]),
      .win_idx_o   (win_idx[c])
    );
  end

  assign cpu_irq_o = win_valid[0];

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      vec_valid_o <= 1'b0;
      vec_o       <= '0;
    end else begin
      vec_valid_o <= ack_i;
      if (ack_i) begin
        if (!win_valid[0])   vec_o <= {pri_base_i, {IDX_W{1'b1}}};
        else if (!casc_hit)  vec_o <= {pri_base_i, win_idx[0]};
        else if (win_valid[1]) vec_o <= {sec_base_i, win_idx[1]};
        else                 vec_o <= {sec_base_i, {IDX_W{1'b1}}};
      end
    end
  end
endmodule

// File: rtl/pic_cascade_chk.sv
module pic_cascade_chk
  import pic_cascade_pkg::*;
#(
  parameter logic [LINES-1:0] MASTER_SEL_MASK = 8'hF8,
  parameter logic [LINES-1:0] SLAVE_SEL_MASK  = 8'hDE
) (
  input logic                    clk_i,
  input logic                    rst_ni,
  input logic [BASE_W-1:0]       pri_base_i,
  input logic [N_CTRL-1:0]       sel_we_i,
  input logic [LINES-1:0]        sel_wdata_i,
  input logic [N_CTRL*LINES-1:0] sel_o,
  input logic                    ack_i,
  input logic                    cpu_irq_o,
  input logic                    vec_valid_o,
  input logic [VEC_W-1:0]        vec_o
);
  // R6
  ack_gives_valid_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ack_i |=> vec_valid_o);

  // R6
  valid_needs_ack_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !ack_i |=> !vec_valid_o);

  // R9
  spurious_pri_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (ack_i && !cpu_irq_o) |=> (vec_o == {$past(pri_base_i), {IDX_W{1'b1}}}));

  // R10
  pri_sel_write_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    sel_we_i[0] |=> (sel_o[LINES-1:0] == ($past(sel_wdata_i) & MASTER_SEL_MASK)));

  // R10
  sec_sel_write_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    sel_we_i[1] |=> (sel_o[2*LINES-1:LINES] == ($past(sel_wdata_i) & SLAVE_SEL_MASK)));

  // R10
  sel_hold_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (sel_we_i == '0) |=> $stable(sel_o));
endmodule

bind pic_cascade pic_cascade_chk #(
  .MASTER_SEL_MASK(MASTER_SEL_MASK),
  .SLAVE_SEL_MASK (SLAVE_SEL_MASK)
) i_chk (.*);

// File: tb/test_pic_cascade.sv
module test_pic_cascade;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [15:0] irq = '0, mask = '0;
  logic [4:0]  pb = 5'h04, sb = 5'h0E;
  logic [1:0]  eoi = '0, sel_we = '0;
  logic [7:0]  sel_wd = '0;
  logic [15:0] sel;
  logic        ack = 1'b0, cpu_irq, vvalid;
  logic [7:0]  vec;
  int          n_chk = 0, n_fail = 0;

  always #2ns clk = ~clk;

  pic_cascade i_pic_cascade (
    .clk_i(clk), .rst_ni(rst_n), .irq_i(irq), .mask_i(mask),
    .pri_base_i(pb), .sec_base_i(sb), .eoi_i(eoi), .sel_we_i(sel_we),
    .sel_wdata_i(sel_wd), .sel_o(sel), .ack_i(ack), .cpu_irq_o(cpu_irq),
    .vec_valid_o(vvalid), .vec_o(vec)
  );

  task automatic chk(string req, logic [31:0] act, logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic cyc(int n = 1);
    repeat (n) @(negedge clk);
  endtask

  task automatic do_ack(string req, logic [7:0] exp_vec);
    ack = 1'b1; cyc(); ack = 1'b0;
    chk({req, " vec_valid"}, vvalid, 1);
    chk({req, " vec"}, vec, exp_vec);
    cyc();
    chk({req, " valid one cycle"}, vvalid, 0);
  endtask

  task automatic do_eoi(int c);
    eoi[c] = 1'b1; cyc(); eoi = '0;
  endtask

  task automatic write_sel(int c, logic [7:0] d);
    sel_we[c] = 1'b1; sel_wd = d; cyc(); sel_we = '0;
  endtask

  task automatic t_reset();
    chk("R10 reset sel", sel, 0);
    chk("R12 reset irq", cpu_irq, 0);
    chk("R6 reset valid", vvalid, 0);
  endtask

  task automatic t_sel();
    write_sel(0, 8'hFF);
    chk("R10 pri mask", sel[7:0], 8'hF8);
    write_sel(1, 8'hFF);
    chk("R10 sec mask", sel[15:8], 8'hDE);
    cyc(2);
    chk("R10 hold", sel, 16'hDEF8);
    write_sel(0, 8'h00); write_sel(1, 8'h00);
    chk("R10 clear", sel, 0);
  endtask

  task automatic t_edge();
    irq[5] = 1'b1; cyc();
    chk("R5 pri latency", cpu_irq, 1);
    irq[5] = 1'b0;
    do_ack("R6", {pb, 3'd5});
    chk("R12 drop after ack", cpu_irq, 0);
    do_eoi(0);
    chk("R2 consumed", cpu_irq, 0);
    irq[6] = 1'b1; cyc(); irq[6] = 1'b0; cyc(3);
    chk("R2 held after fall", cpu_irq, 1);
    do_ack("R2", {pb, 3'd6});
    do_eoi(0);
  endtask

  task automatic t_prio();
    irq[3] = 1'b1; irq[6] = 1'b1; cyc(); irq = '0;
    do_ack("R4 lowest wins", {pb, 3'd3});
    chk("R4 nested block", cpu_irq, 0);
    do_eoi(0);
    chk("R12 after eoi", cpu_irq, 1);
    do_ack("R4 second", {pb, 3'd6});
    irq[1] = 1'b1; cyc(); irq[1] = 1'b0;
    chk("R4 preempt", cpu_irq, 1);
    do_ack("R4 preempt", {pb, 3'd1});
    irq[4] = 1'b1; cyc(); irq[4] = 1'b0;
    chk("R4 blocked by 1", cpu_irq, 0);
    do_eoi(0);
    chk("R11 lowest removed", cpu_irq, 1);
    do_ack("R11", {pb, 3'd4});
    do_eoi(0); do_eoi(0);
    chk("R11 idle", cpu_irq, 0);
  endtask

  task automatic t_mask();
    mask[5] = 1'b1; irq[5] = 1'b1; cyc(); irq[5] = 1'b0; cyc();
    chk("R13 masked", cpu_irq, 0);
    mask[5] = 1'b0; cyc();
    chk("R13 unmasked", cpu_irq, 1);
    do_ack("R13", {pb, 3'd5});
    do_eoi(0);
  endtask

  task automatic t_cascade();
    irq[12] = 1'b1; cyc();
    chk("R5 one edge", cpu_irq, 0);
    irq[12] = 1'b0; cyc();
    chk("R5 two edges", cpu_irq, 1);
    do_ack("R1 R7", {sb, 3'd4});
    chk("R7 served", cpu_irq, 0);
    do_eoi(1); do_eoi(0);
    chk("R7 idle", cpu_irq, 0);
  endtask

  task automatic t_level();
    write_sel(0, 8'h10);
    irq[4] = 1'b1; cyc();
    chk("R3 level on", cpu_irq, 1);
    irq[4] = 1'b0; cyc();
    chk("R3 level drop", cpu_irq, 0);
    irq[4] = 1'b1; cyc();
    do_ack("R3", {pb, 3'd4});
    do_eoi(0);
    chk("R3 still pending", cpu_irq, 1);
    irq[4] = 1'b0; cyc();
    chk("R3 released", cpu_irq, 0);
    write_sel(0, 8'h00);
  endtask

  task automatic t_spur_sec();
    write_sel(1, 8'h02);
    irq[9] = 1'b1; cyc(2);
    chk("R5 cascade level", cpu_irq, 1);
    irq[9] = 1'b0; cyc();
    chk("R8 cascade latched", cpu_irq, 1);
    do_ack("R8", {sb, 3'd7});
    chk("R8 after", cpu_irq, 0);
    do_eoi(0);
    write_sel(1, 8'h00);
  endtask

  task automatic t_spur_pri();
    do_ack("R9", {pb, 3'd7});
    chk("R9 no change", cpu_irq, 0);
    irq[0] = 1'b1; cyc(); irq[0] = 1'b0;
    do_ack("R9 then real", {pb, 3'd0});
    do_eoi(0);
  endtask

  initial begin
    #400us;
    n_fail++;
    $display("FAIL watchdog actual=running expected=done");
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_fail);
    $finish;
  end

  initial begin
    cyc(3); rst_n = 1'b1; cyc();
    t_reset();
    t_sel();
    t_edge();
    t_prio();
    t_mask();
    t_cascade();
    t_level();
    t_spur_sec();
    t_spur_pri();
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_fail);
    $finish;
  end
endmodule